// File: doc/BRIEF.md
# Per-Endpoint Ping-Pong Buffer Selector

This block holds one even/odd buffer-select bit for every endpoint and direction of a 16-endpoint USB device controller. When the transfer engine finishes a transaction on an endpoint, it pulses a done strobe with the endpoint number and direction. The selector then flips that pair's bit, so the next transaction uses the other buffer of the pair. A pair only flips if double buffering is enabled for it. A 2-bit mode input sets which pairs are enabled.

A lookup port returns the current select bit for any endpoint and direction. The descriptor fetch logic uses it to pick the even or odd buffer descriptor. A level-sensitive force-even control holds every bit at even for as long as it is set. Pairs that are not double buffered always read even.

Top module: `pp_buf_sel`

## Requirements
- R1: Mode 0 (`mode`=2'b00) disables double buffering everywhere. Every lookup returns 0 (even), and done strobes change nothing.
- R2: In mode 1 (`mode`=2'b01), only endpoint 0 in the OUT direction (`dir`=0) toggles. Endpoint 0 IN and every other endpoint stay even.
- R3: In mode 2 (`mode`=2'b10), all 32 pairs (endpoints 0 to 15, OUT `dir`=0 and IN `dir`=1) toggle on their own done strobe.
- R4: In mode 3 (`mode`=2'b11), endpoints 1 to 15 toggle in both directions. Both directions of endpoint 0 stay even.
- R5: While `force_even` is 1, every lookup returns even and done strobes are ignored. After release, pointers start from even.
- R6: If `force_even` and a done strobe fall in the same cycle, the strobed pair ends up even.
- R7: A done strobe sampled at a clock edge changes the lookup result for that pair right after that edge. Lookup is combinational on `q_ep`/`q_dir`.
- R8: On a mode change, pairs that become disabled read even. Pairs that remain enabled keep their value.
- R9: After a synchronous active-low reset (`rst_n`=0 at a clock edge), all 32 pointers read even.
- R10: In mode 0, asserting and releasing `force_even` has no visible effect. All pointers are even afterwards, including after a switch to mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Double-buffering mode, 0 to 3 |
| force_even | input | 1 | Level control holding all pointers even |
| done | input | 1 | Transaction-complete strobe |
| done_ep | input | 4 | Endpoint of the completed transaction |
| done_dir | input | 1 | Direction of the completed transaction, 0 OUT, 1 IN |
| q_ep | input | 4 | Lookup endpoint |
| q_dir | input | 1 | Lookup direction, 0 OUT, 1 IN |
| rd_ptr | output | 1 | Select bit of the looked-up pair, 0 even, 1 odd |

## Verification
The bench targets the mask edges: endpoint 0 IN in mode 1 and both endpoint-0 directions in mode 3. A mask decoded off by one direction or endpoint would let those pairs toggle. It changes mode from 2 to 3 with every pair odd. A design that does not clear newly disabled pairs would report endpoint 0 as odd, and one that clears everything would lose endpoint 1 to 15 state. It puts force-even and a strobe in the same cycle, where a design with the wrong priority would leave the pair odd. It also strobes while force-even is held, which would leave stale odd bits after release.

// File: rtl/pp_pkg.sv
// Shared types for the ping-pong buffer selector.
// Assumes direction encoding 0 = OUT, 1 = IN.
package pp_pkg;
    typedef enum logic [1:0] {
        PP_OFF     = 2'b00,
        PP_EP0_OUT = 2'b01,
        PP_ALL     = 2'b10,
        PP_NO_EP0  = 2'b11
    } pp_mode_e;

    localparam logic DIR_OUT = 1'b0;
    localparam logic DIR_IN  = 1'b1;
endpackage

// File: rtl/pp_mask_gen.sv
// Decodes the double-buffering mode into one enable bit per pair.
// Pair index = {endpoint, direction}. Purely combinational.
module pp_mask_gen
    import pp_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int NPAIR = 2 * NUM_EP
) (
    input  pp_mode_e         mode,
    output logic [NPAIR-1:0] en_vec
);
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        for (genvar d = 0; d < 2; d++) begin : g_dir
            localparam bit IS_EP0 = (e == 0);
            localparam bit IS_OUT = (d == 0);
            // Enable for this endpoint/direction under the current mode.
            always_comb begin
                case (mode)
                    PP_OFF:     en_vec[2*e+d] = 1'b0;
                    PP_EP0_OUT: en_vec[2*e+d] = IS_EP0 && IS_OUT;
                    PP_ALL:     en_vec[2*e+d] = 1'b1;
                    default:    en_vec[2*e+d] = !IS_EP0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pp_ptr_bank.sv
// Bank of even/odd pointer flops, one per pair.
// A disabled pair is cleared. force_even clears every pair and wins over a strobe.
// Assumes done_idx is valid whenever done is high.
module pp_ptr_bank #(
    parameter int NPAIR = 32,
    localparam int IW = $clog2(NPAIR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] en_vec,
    input  logic             force_even,
    input  logic             done,
    input  logic [IW-1:0]    done_idx,
    output logic [NPAIR-1:0] ptr_q
);
    for (genvar i = 0; i < NPAIR; i++) begin : g_ptr
        // Update one pointer: reset, clear, force, or toggle on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[i] <= 1'b0;
            else if (!en_vec[i] || force_even)
                ptr_q[i] <= 1'b0;
            else if (done && done_idx == IW'(i))
                ptr_q[i] <= ~ptr_q[i];
        end
    end
endmodule

// File: rtl/pp_read_mux.sv
// Selects the queried pair's pointer. The result is gated so that disabled
// pairs and a held force-even read even without waiting a cycle.
module pp_read_mux #(
    parameter int NPAIR = 32,
    localparam int IW = $clog2(NPAIR)
) (
    input  logic [NPAIR-1:0] ptr_q,
    input  logic [NPAIR-1:0] en_vec,
    input  logic             force_even,
    input  logic [IW-1:0]    q_idx,
    output logic             rd_ptr
);
    // Gated lookup of the addressed pointer.
    always_comb rd_ptr = ptr_q[q_idx] & en_vec[q_idx] & ~force_even;
endmodule

// File: rtl/pp_buf_sel.sv
// Top: per-endpoint ping-pong buffer selector for NUM_EP endpoints.
// Pair index is {endpoint, direction}, with direction 0 = OUT and 1 = IN.
module pp_buf_sel #(
    parameter int NUM_EP = 16,
    localparam int EPW = $clog2(NUM_EP),
    localparam int NPAIR = 2 * NUM_EP,
    localparam int IW = EPW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode,
    input  logic           force_even,
    input  logic           done,
    input  logic [EPW-1:0] done_ep,
    input  logic           done_dir,
    input  logic [EPW-1:0] q_ep,
    input  logic           q_dir,
    output logic           rd_ptr
);
    logic [NPAIR-1:0] en_vec;
    logic [NPAIR-1:0] ptr_q;

    pp_mask_gen #(.NUM_EP(NUM_EP)) u_mask (
        .mode   (pp_pkg::pp_mode_e'(mode)),
        .en_vec (en_vec)
    );

    pp_ptr_bank #(.NPAIR(NPAIR)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_vec     (en_vec),
        .force_even (force_even),
        .done       (done),
        .done_idx   ({done_ep, done_dir}),
        .ptr_q      (ptr_q)
    );

    pp_read_mux #(.NPAIR(NPAIR)) u_rd (
        .ptr_q      (ptr_q),
        .en_vec     (en_vec),
        .force_even (force_even),
        .q_idx      ({q_ep, q_dir}),
        .rd_ptr     (rd_ptr)
    );
endmodule

// File: rtl/pp_buf_sel_chk.sv
// Assertion checker for pp_buf_sel, attached through bind.
module pp_buf_sel_chk #(
    parameter int NUM_EP = 16,
    localparam int EPW = $clog2(NUM_EP),
    localparam int NPAIR = 2 * NUM_EP
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             force_even,
    input logic             done,
    input logic [EPW-1:0]   done_ep,
    input logic             done_dir,
    input logic [NPAIR-1:0] ptr_vec,
    input logic [NPAIR-1:0] en_vec,
    input logic             rd_ptr
);
    logic [EPW:0] didx;
    always_comb didx = {done_ep, done_dir};

    p_off_reads_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |-> !rd_ptr);
    p_ep0out_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $stable(mode)) |-> ptr_vec[NPAIR-1:1] == '0);
    p_no_ep0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && $stable(mode)) |-> ptr_vec[1:0] == 2'b00);
    p_force_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_even |=> ptr_vec == '0);
    p_force_reads_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_even |-> !rd_ptr);
    p_force_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_even && done) |=> !ptr_vec[$past(didx)]);
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !force_even && en_vec[didx]) |=> ptr_vec[$past(didx)] != $past(ptr_vec[didx]));
    p_disabled_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode) |-> (ptr_vec & ~en_vec) == '0);
endmodule

bind pp_buf_sel pp_buf_sel_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .force_even (force_even),
    .done       (done),
    .done_ep    (done_ep),
    .done_dir   (done_dir),
    .ptr_vec    (ptr_q),
    .en_vec     (en_vec),
    .rd_ptr     (rd_ptr)
);

// File: tb/sim_pp_buf_sel.sv
// Directed bench for pp_buf_sel. Inputs are driven on the falling edge.
module sim_pp_buf_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       force_even = 1'b0;
    logic       done = 1'b0;
    logic [3:0] done_ep = '0;
    logic       done_dir = 1'b0;
    logic [3:0] q_ep = '0;
    logic       q_dir = 1'b0;
    logic       rd_ptr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit exp_ptr [32];
    logic [1:0] m_mode = 2'b00;
    bit m_force = 0;

    always #5 clk = ~clk;

    pp_buf_sel u0 (.*);

    // Expected enable for a pair, taken from the requirements.
    function automatic bit pair_en(logic [1:0] m, int ep, int dir);
        case (m)
            2'b00: return 0;
            2'b01: return ep == 0 && dir == 0;
            2'b10: return 1;
            default: return ep != 0;
        endcase
    endfunction

    task automatic chk(string req, bit act, bit exp, int ep, int dir);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ep%0d dir%0d: actual %0b expected %0b", req, ep, dir, act, exp);
        end
    endtask

    task automatic look(string req, int ep, int dir);
        q_ep = 4'(ep); q_dir = dir[0];
        #1 chk(req, rd_ptr, exp_ptr[2*ep+dir], ep, dir);
    endtask

    task automatic look_all(string req);
        @(negedge clk);
        for (int i = 0; i < 32; i++) look(req, i / 2, i % 2);
    endtask

    task automatic strobe(int ep, int dir);
        @(negedge clk);
        done = 1; done_ep = 4'(ep); done_dir = dir[0];
        @(negedge clk);
        done = 0;
        if (!m_force && pair_en(m_mode, ep, dir)) exp_ptr[2*ep+dir] = !exp_ptr[2*ep+dir];
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode = m; m_mode = m;
        for (int i = 0; i < 32; i++) if (!pair_en(m, i / 2, i % 2)) exp_ptr[i] = 0;
        @(negedge clk);
    endtask

    task automatic set_force(bit f);
        @(negedge clk);
        force_even = f; m_force = f;
        if (f) for (int i = 0; i < 32; i++) exp_ptr[i] = 0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) exp_ptr[i] = 0;
        look_all("R9");
    endtask

    task automatic t_mode_off;
        set_mode(2'b00);
        strobe(0, 0); strobe(5, 1); strobe(15, 0);
        look_all("R1");
    endtask

    task automatic t_mode_ep0out;
        set_mode(2'b01);
        strobe(0, 0); strobe(0, 1); strobe(3, 1); strobe(1, 0);
        look_all("R2");
        strobe(0, 0);
        look("R2", 0, 0);
    endtask

    task automatic t_mode_all;
        set_mode(2'b10);
        for (int i = 0; i < 32; i++) begin
            strobe(i / 2, i % 2);
            look("R7", i / 2, i % 2);
        end
        look_all("R3");
    endtask

    task automatic t_mode_change;
        set_mode(2'b11);
        look_all("R8");
        strobe(0, 1); strobe(0, 0); strobe(7, 0);
        look_all("R4");
        set_mode(2'b10);
        look_all("R8");
    endtask

    task automatic t_force;
        strobe(4, 1); strobe(9, 0);
        set_force(1);
        look_all("R5");
        strobe(4, 1); strobe(12, 0);
        look_all("R5");
        set_force(0);
        look_all("R5");
        strobe(12, 0);
        look("R5", 12, 0);
    endtask

    task automatic t_force_vs_strobe;
        strobe(6, 1);
        @(negedge clk);
        force_even = 1; done = 1; done_ep = 4'd6; done_dir = 1'b1;
        @(negedge clk);
        force_even = 0; done = 0;
        for (int i = 0; i < 32; i++) exp_ptr[i] = 0;
        look_all("R6");
    endtask

    task automatic t_force_in_off;
        set_mode(2'b00);
        set_force(1);
        strobe(2, 0);
        set_force(0);
        look_all("R10");
        set_mode(2'b10);
        look_all("R10");
        strobe(2, 0);
        look("R10", 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_mode_off();
        t_mode_ep0out();
        t_mode_all();
        t_mode_change();
        t_force();
        t_force_vs_strobe();
        t_force_in_off();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule